// File: doc/BRIEF.md
# Processor Trap Dispatch Unit

This block gathers trap requests raised around a processor core and picks exactly one of them to take. Each of the eight trap classes has two request lines. One carries a synchronous request, tied to the instruction now executing. The other carries an asynchronous request, such as an external non-maskable event or a fault reported late by a memory system. Every request line comes with an identification number (TIN) that gives the exact cause within its class. For example, in class 0 the TIN tells a translation miss apart from a page access violation. In the classes that serve software trap instructions, it tells a system call apart from a trap on overflow or a trap on sticky overflow.

For the trap it selects, the block forms the handler entry address from a programmable vector base and the class number, with a fixed 32-byte stride per class. In the same registered cycle it raises a one-cycle redirect pulse that tells the pipeline to flush and fetch from that address. It also latches the class, the TIN and a synchronous/asynchronous flag into a status register.

Asynchronous traps never pass through the interrupt path. Nothing can mask them and they do not touch the interrupt priority. They wait in a per-class pending store until an instruction boundary. One trap, the free-context-list underflow, is flagged as unrecoverable, and that flag stays set until reset.

Top module: `trap_dispatch`

## Requirements
- R1: The handler address is the vector base with bits [7:5] replaced by the class number and bits [4:0] zero. It appears on the clock edge that takes the trap.
- R2: The redirect output is high for exactly the one cycle after each clock edge that takes a trap. After an edge that takes none, it is low.
- R3: When several synchronous requests are present in one cycle, the lowest-numbered class is taken.
- R4: A synchronous request is always taken ahead of any asynchronous request in the same cycle. The asynchronous request is not lost and stays pending.
- R5: An asynchronous request needs only a one-cycle pulse. It stays pending until the boundary strobe is high and no synchronous request is present. Taking it clears it.
- R6: When several asynchronous requests are pending or arriving, the lowest-numbered class is taken.
- R7: On each take, the status outputs capture the class, the TIN carried with that request, and a flag that is 1 for asynchronous and 0 for synchronous. They hold until the next take.
- R8: A vector-base write is accepted only when bits [7:0] of the written value are zero. Any other write is ignored. A trap taken on the same edge as an accepted write still uses the old base.
- R9: Taking class 3 with TIN 4 (free-context-list underflow) sets the unrecoverable output. It stays set through later traps until reset.
- R10: After reset, redirect, status and the unrecoverable output are 0, nothing is pending, and the vector base equals its reset parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sync_req | input | 8 | Synchronous request per class, bit n = class n |
| sync_tin | input | 8*TIN_W | TIN per synchronous class, class n at [n*TIN_W +: TIN_W] |
| async_req | input | 8 | Asynchronous request pulse per class |
| async_tin | input | 8*TIN_W | TIN per asynchronous class, sampled while its request is high |
| boundary | input | 1 | Instruction-boundary strobe gating asynchronous takes |
| vb_we | input | 1 | Vector base write enable |
| vb_wdata | input | ADDR_W | Vector base write value |
| redirect | output | 1 | One-cycle flush and redirect pulse |
| handler_addr | output | ADDR_W | Handler entry address of the last trap taken |
| stat_class | output | 3 | Class of the last trap taken |
| stat_tin | output | TIN_W | TIN of the last trap taken |
| stat_async | output | 1 | 1 if the last trap taken was asynchronous |
| unrecoverable | output | 1 | Sticky unrecoverable-trap flag |

## Verification
The hardest state to reach from the ports is a set of asynchronous requests that were pulsed in earlier cycles and are still waiting. A later cycle must then decide between these old pending entries, newly arriving pulses and a synchronous request. The vector table sets this up on purpose. It pulses a class while the boundary strobe is low. It lets a synchronous request preempt a boundary cycle while a lower async class arrives. It then shows that the old pending class beats a higher class that arrives later. The tests that follow cover a rejected base write, an accepted write on the same edge as a trap, and the sticky unrecoverable flag.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int unsigned CLASS_COUNT = 8;
   localparam int unsigned CLASS_W     = 3;
   localparam int unsigned STRIDE_LOG2 = 5;
   localparam int unsigned ALIGN_W     = CLASS_W + STRIDE_LOG2;

   typedef logic [CLASS_W-1:0] trap_class_t;

   typedef enum logic {
      SRC_SYNC  = 1'b0,
      SRC_ASYNC = 1'b1
   } trap_src_e;
endpackage

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
   parameter int unsigned N = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic          valid,
   output logic [IW-1:0] idx
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   generate
      if (N < 2) begin : g_bad_n
         $error("trap_prio_pick: N must be at least 2");
      end
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign seen[i+1] = seen[i] | req[i];
         assign grant[i]  = req[i] & ~seen[i];
      end
   endgenerate

   assign valid = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IW'(i);
      end
   end
endmodule

// File: rtl/trap_async_pend.sv
module trap_async_pend #(
   parameter int unsigned N     = 8,
   parameter int unsigned TIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     arr,
   input  logic [N*TIN_W-1:0] arr_tin,
   input  logic [N-1:0]     clr,
   output logic [N-1:0]     eff,
   output logic [N*TIN_W-1:0] eff_tin
);
   logic [N-1:0]       pend_q;
   logic [N*TIN_W-1:0] tin_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q[i]              <= 1'b0;
               tin_q[i*TIN_W +: TIN_W] <= '0;
            end else begin
               pend_q[i] <= (pend_q[i] | arr[i]) & ~clr[i];
               if (arr[i]) tin_q[i*TIN_W +: TIN_W] <= arr_tin[i*TIN_W +: TIN_W];
            end
         end
         assign eff[i] = pend_q[i] | arr[i];
         assign eff_tin[i*TIN_W +: TIN_W] = arr[i] ? arr_tin[i*TIN_W +: TIN_W]
                                                   : tin_q[i*TIN_W +: TIN_W];
      end
   endgenerate

   // R5: a taken slot is empty on the next cycle
   p_taken_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr != '0) |=> ((pend_q & $past(clr)) == '0));

   // R5: a pending slot that was not taken stays pending
   p_pending_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != '0) |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0));
endmodule

// File: rtl/trap_vbase.sv
module trap_vbase #(
   parameter int unsigned          ADDR_W  = 32,
   parameter int unsigned          ALIGN_W = 8,
   parameter logic [ADDR_W-1:0]    RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] base
);
   logic aligned;
   assign aligned = (wdata[ALIGN_W-1:0] == '0);

   generate
      if (RST_VAL[ALIGN_W-1:0] != '0) begin : g_bad_rst
         $error("trap_vbase: reset value must have its low bits clear");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              base <= RST_VAL;
      else if (we && aligned)  base <= wdata;
   end

   // R8: base never holds a misaligned value
   p_base_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      base[ALIGN_W-1:0] == '0);

   // R8: misaligned write leaves the base unchanged
   p_bad_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (wdata[ALIGN_W-1:0] != '0)) |=> $stable(base));
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
   import trap_pkg::*;
#(
   parameter int unsigned       ADDR_W            = 32,
   parameter int unsigned       TIN_W             = 8,
   parameter logic [ADDR_W-1:0] VB_RESET          = 32'h0000_1000,
   parameter int unsigned       FATAL_CLASS       = 3,
   parameter int unsigned       FATAL_TIN         = 4,
   parameter bit                ASYNC_AT_BOUNDARY = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CLASS_COUNT-1:0]       sync_req,
   input  logic [CLASS_COUNT*TIN_W-1:0] sync_tin,
   input  logic [CLASS_COUNT-1:0]       async_req,
   input  logic [CLASS_COUNT*TIN_W-1:0] async_tin,
   input  logic                         boundary,
   input  logic                         vb_we,
   input  logic [ADDR_W-1:0]            vb_wdata,
   output logic                         redirect,
   output logic [ADDR_W-1:0]            handler_addr,
   output logic [CLASS_W-1:0]           stat_class,
   output logic [TIN_W-1:0]             stat_tin,
   output logic                         stat_async,
   output logic                         unrecoverable
);
   localparam int unsigned N = CLASS_COUNT;

   generate
      if (ADDR_W <= ALIGN_W) begin : g_bad_addr
         $error("trap_dispatch: ADDR_W too small for the vector table");
      end
      if (FATAL_CLASS >= N) begin : g_bad_fatal
         $error("trap_dispatch: FATAL_CLASS out of range");
      end
      if (TIN_W < 3) begin : g_bad_tin
         $error("trap_dispatch: TIN_W too narrow");
      end
   endgenerate

   logic [ADDR_W-1:0]  vbase;
   logic [N-1:0]       s_grant, a_grant, a_eff, a_cand;
   logic               s_valid, a_valid, async_open, take;
   trap_class_t        s_idx, a_idx, sel_cls;
   logic [N*TIN_W-1:0] a_tin_eff;
   logic [TIN_W-1:0]   sel_tin;
   trap_src_e          sel_src;

   trap_vbase #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .RST_VAL(VB_RESET)) u_vbase (
      .clk(clk), .rst_n(rst_n), .we(vb_we), .wdata(vb_wdata), .base(vbase));

   trap_async_pend #(.N(N), .TIN_W(TIN_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .arr(async_req), .arr_tin(async_tin),
      .clr(a_grant), .eff(a_eff), .eff_tin(a_tin_eff));

   trap_prio_pick #(.N(N)) u_sync_pick (
      .req(sync_req), .grant(s_grant), .valid(s_valid), .idx(s_idx));

   generate
      if (ASYNC_AT_BOUNDARY) begin : g_gate_boundary
         assign async_open = boundary & ~s_valid;
      end else begin : g_gate_any
         assign async_open = ~s_valid;
      end
   endgenerate

   assign a_cand = a_eff & {N{async_open}};

   trap_prio_pick #(.N(N)) u_async_pick (
      .req(a_cand), .grant(a_grant), .valid(a_valid), .idx(a_idx));

   assign take    = s_valid | a_valid;
   assign sel_src = s_valid ? SRC_SYNC : SRC_ASYNC;
   assign sel_cls = s_valid ? s_idx : a_idx;
   assign sel_tin = s_valid ? sync_tin[s_idx*TIN_W +: TIN_W]
                            : a_tin_eff[a_idx*TIN_W +: TIN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect      <= 1'b0;
         handler_addr  <= '0;
         stat_class    <= '0;
         stat_tin      <= '0;
         stat_async    <= 1'b0;
         unrecoverable <= 1'b0;
      end else begin
         redirect <= take;
         if (take) begin
            handler_addr <= {vbase[ADDR_W-1:ALIGN_W], sel_cls, {STRIDE_LOG2{1'b0}}};
            stat_class   <= sel_cls;
            stat_tin     <= sel_tin;
            stat_async   <= (sel_src == SRC_ASYNC);
            if ((sel_cls == trap_class_t'(FATAL_CLASS)) && (sel_tin == TIN_W'(FATAL_TIN)))
               unrecoverable <= 1'b1;
         end
      end
   end

   // R2: pulse follows a take, and only a take
   p_pulse_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> redirect);
   p_no_pulse_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !redirect);

   // R1: address slot matches the reported class
   p_addr_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (handler_addr[ALIGN_W-1:STRIDE_LOG2] == stat_class
                    && handler_addr[STRIDE_LOG2-1:0] == '0));

   // R4: a synchronous request always wins the cycle
   p_sync_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_req != '0) |=> (redirect && !stat_async));

   // R7: status is stable while nothing is taken
   p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(stat_class) && $stable(stat_tin) && $stable(stat_async)));

   // R9: unrecoverable flag is sticky
   p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      unrecoverable |=> unrecoverable);

   // R3/R6: never more than one class granted per picker
   p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(s_grant) && $onehot0(a_grant));
endmodule

// File: tb/trap_dispatch_bench.sv
module trap_dispatch_bench;
   localparam int unsigned TIN_W = 8;
   localparam logic [31:0] BASE0 = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sync_req = '0, async_req = '0;
   logic [63:0] sync_tin, async_tin;
   logic        boundary = 1'b0, vb_we = 1'b0;
   logic [31:0] vb_wdata = '0;
   logic        redirect, stat_async, unrecoverable;
   logic [31:0] handler_addr;
   logic [2:0]  stat_class;
   logic [7:0]  stat_tin;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   trap_dispatch u_trap_dispatch (
      .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .sync_tin(sync_tin),
      .async_req(async_req), .async_tin(async_tin), .boundary(boundary),
      .vb_we(vb_we), .vb_wdata(vb_wdata), .redirect(redirect),
      .handler_addr(handler_addr), .stat_class(stat_class), .stat_tin(stat_tin),
      .stat_async(stat_async), .unrecoverable(unrecoverable));

   typedef struct packed {
      logic [7:0] s;
      logic [7:0] a;
      logic       b;
      logic       r;
      logic [2:0] c;
      logic       as;
   } vec_t;

   localparam vec_t TBL [9] = '{
      '{8'b0000_0100, 8'b0000_0000, 1'b0, 1'b1, 3'd2, 1'b0}, // R3 single sync
      '{8'b1010_0000, 8'b0000_0000, 1'b1, 1'b1, 3'd5, 1'b0}, // R3 lowest sync
      '{8'b0000_0000, 8'b0100_0000, 1'b0, 1'b0, 3'd5, 1'b0}, // R5 no boundary
      '{8'b0000_0000, 8'b0000_0000, 1'b1, 1'b1, 3'd6, 1'b1}, // R5 pending taken
      '{8'b0000_1000, 8'b0000_0010, 1'b1, 1'b1, 3'd3, 1'b0}, // R4 sync beats async
      '{8'b0000_0000, 8'b1000_0000, 1'b1, 1'b1, 3'd1, 1'b1}, // R6 old pending lower
      '{8'b0000_0000, 8'b0000_0000, 1'b1, 1'b1, 3'd7, 1'b1}, // R6 next pending
      '{8'b0000_0000, 8'b0000_0000, 1'b1, 1'b0, 3'd7, 1'b1}, // R7 hold
      '{8'b1111_1111, 8'b0000_0000, 1'b0, 1'b1, 3'd0, 1'b0}  // R3 all sync
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cyc;
      @(posedge clk);
      #5;
   endtask

   task automatic idle;
      @(negedge clk);
      sync_req = '0; async_req = '0; boundary = 1'b0; vb_we = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 8; c++) begin
         sync_tin[c*8 +: 8]  = 8'h10 + 8'(c);
         async_tin[c*8 +: 8] = 8'h80 + 8'(c);
      end
      repeat (3) @(posedge clk);
      #5;
      chk("R10 redirect", 32'(redirect), 0);
      chk("R10 class", 32'(stat_class), 0);
      chk("R10 unrec", 32'(unrecoverable), 0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         sync_req = TBL[i].s; async_req = TBL[i].a; boundary = TBL[i].b;
         cyc();
         chk("R2 redirect", 32'(redirect), 32'(TBL[i].r));
         chk("R7 class", 32'(stat_class), 32'(TBL[i].c));
         chk("R7 async", 32'(stat_async), 32'(TBL[i].as));
         chk("R7 tin", 32'(stat_tin), 32'((TBL[i].as ? 8'h80 : 8'h10) + 8'(TBL[i].c)));
         if (TBL[i].r) chk("R1 addr", handler_addr, BASE0 + 32'(TBL[i].c) * 32);
      end
      chk("R9 not set by others", 32'(unrecoverable), 0);

      // R8: misaligned write ignored
      @(negedge clk); sync_req = '0; vb_we = 1'b1; vb_wdata = 32'h0000_2001;
      @(negedge clk); vb_we = 1'b0; sync_req = 8'b0000_0100;
      cyc();
      chk("R8 bad write ignored", handler_addr, 32'h0000_1040);

      // R8: accepted write, same-edge trap uses old base
      @(negedge clk); vb_we = 1'b1; vb_wdata = 32'h0000_2300; sync_req = 8'b0001_0000;
      cyc();
      chk("R8 old base same edge", handler_addr, 32'h0000_1080);
      @(negedge clk); vb_we = 1'b0;
      cyc();
      chk("R8 new base", handler_addr, 32'h0000_2380);
      idle();
      cyc();
      chk("R2 pulse ends", 32'(redirect), 0);

      // R7: class 0 TIN distinguishes causes
      @(negedge clk); sync_tin[7:0] = 8'h05; sync_req = 8'b0000_0001;
      cyc();
      chk("R7 class0 tin a", 32'(stat_tin), 32'h05);
      @(negedge clk); sync_tin[7:0] = 8'h06;
      cyc();
      chk("R7 class0 tin b", 32'(stat_tin), 32'h06);

      // R9: fatal trap, sticky
      @(negedge clk); sync_tin[31:24] = 8'h04; sync_req = 8'b0000_1000;
      cyc();
      chk("R9 set", 32'(unrecoverable), 1);
      @(negedge clk); sync_req = 8'b0000_0010;
      cyc();
      chk("R9 sticky", 32'(unrecoverable), 1);
      chk("R9 later class", 32'(stat_class), 1);
      idle();
      repeat (3) cyc();
      chk("R9 held idle", 32'(unrecoverable), 1);

      // R10: reset clears flag and restores base
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R10 unrec cleared", 32'(unrecoverable), 0);
      @(negedge clk); sync_req = 8'b0000_0001;
      cyc();
      chk("R10 base restored", handler_addr, BASE0);
      idle();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule